// File: doc/BRIEF.md
# GPR Partial-Write Merge Unit

This block is the writeback end of a general-purpose register file that holds sixteen 64-bit registers. Each cycle it may accept one write. The write carries a destination index, an execution result, an operand width code and two qualifiers: the current execution mode and whether the instruction carried the register-extension prefix. The block merges the result into the old register contents. The width decides which bits are replaced and which are kept or cleared.

The block also decides whether the destination can be reached at all. A write that names a register the current mode cannot reach is discarded, and an error pulse follows on the next cycle. Two combinational read ports show the register contents as the current mode sees them.

Top module: `gpr_wb_merge`

## Requirements
- R1: After reset every register reads as zero on both read ports and `wr_err` is low.
- R2: In 64-bit mode (`mode_long`=1), a write with width code 3 (64 bits) replaces all 64 bits of the destination.
- R3: In 64-bit mode, a write with width code 2 (32 bits) places the result in bits 31:0 and clears bits 63:32 of the destination.
- R4: A write with width code 0 (8 bits) or 1 (16 bits) replaces only bits 7:0 or 15:0 and keeps every higher bit of the destination, in either mode.
- R5: In 64-bit mode, indices 8 to 15 can be written only when `wr_rex` is 1. Without it the write is dropped, the register keeps its value, and `wr_err` is high in the following cycle.
- R6: In legacy mode (`mode_long`=0), only indices 0 to 7 with width codes 0, 1 or 2 are accepted. Any other index, or width code 3, is dropped and raises `wr_err` in the following cycle. `wr_rex` has no effect in this mode.
- R7: In legacy mode a 32-bit write replaces bits 31:0 and keeps bits 63:32. The read ports return bits 63:32 as zero while `mode_long` is 0, and show the kept bits again once 64-bit mode returns.
- R8: A write takes effect at the next rising clock edge. Before that edge the read ports still show the old value. The two read ports are combinational and independent of each other.
- R9: `wr_err` is a one-cycle pulse per rejected write. It is low in any cycle that follows a cycle without a rejected write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_long | input | 1 | 1 = 64-bit mode, 0 = legacy/compatibility mode |
| wr_en | input | 1 | Write request this cycle |
| wr_rex | input | 1 | Instruction carried the register-extension prefix |
| wr_idx | input | 4 | Destination register index |
| wr_width | input | 2 | Width code: 0=8, 1=16, 2=32, 3=64 bits |
| wr_data | input | 64 | Execution result, low-aligned |
| wr_err | output | 1 | Pulse one cycle after a rejected write |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 64 | Read port A data, mode-masked |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 64 | Read port B data, mode-masked |

## Verification
The assertions assume that `mode_long` and `wr_rex` are steady around each clock edge. They also assume that a width code is meaningful only together with `wr_en`, so the checks on merged bits are made only when a write was both requested and accepted. The stimulus changes all inputs only on falling edges and holds the mode through each write and the sample after it. It visits every width code, indices on both sides of the reachable boundary, and both settings of the prefix. The mode is switched only between writes.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2,
        WID_64 = 2'd3
    } wid_e;
endpackage

// File: rtl/gpr_access_check.sv
module gpr_access_check
    import gpr_pkg::*;
#(
    parameter int NREGS       = 16,
    parameter int LEGACY_REGS = 8,
    localparam int IW         = $clog2(NREGS)
) (
    input  logic          req,
    input  logic          long_mode,
    input  logic          rex,
    input  logic [IW-1:0] idx,
    input  wid_e          wid,
    output logic          accept,
    output logic          reject
);
    logic low_idx;

    always_comb begin
        low_idx = (int'(idx) < LEGACY_REGS);
        if (long_mode) begin
            accept = req && (low_idx || rex);
        end else begin
            accept = req && low_idx && (wid != WID_64);
        end
        reject = req && !accept;
    end
endmodule

// File: rtl/gpr_merge.sv
module gpr_merge
    import gpr_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int HALF = XLEN / 2
) (
    input  logic            long_mode,
    input  wid_e            wid,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] new_val,
    output logic [XLEN-1:0] merged
);
    logic [XLEN-1:0] keep_mask;

    always_comb begin
        unique case (wid)
            WID_8:   keep_mask = {{(XLEN-8){1'b1}}, 8'h00};
            WID_16:  keep_mask = {{(XLEN-16){1'b1}}, 16'h0000};
            WID_32:  keep_mask = long_mode ? '0 : {{HALF{1'b1}}, {HALF{1'b0}}};
            default: keep_mask = '0;
        endcase
        merged = (old_val & keep_mask) | (new_val & ~keep_mask);
        if (wid == WID_32) begin
            merged[XLEN-1:HALF] = long_mode ? '0 : old_val[XLEN-1:HALF];
        end
    end
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
    parameter int NREGS = 16,
    parameter int XLEN  = 64,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IW-1:0]   widx,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] regs_o [NREGS]
);
    logic [XLEN-1:0] regs_d [NREGS];
    logic [XLEN-1:0] regs_q [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we) begin
            regs_d[widx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign regs_o = regs_q;

    for (genvar g = 0; g < NREGS; g++) begin : g_hold
        // R8: an entry that was not addressed by a write keeps its value
        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (int'(widx) == g)) |=> $stable(regs_q[g]));
    end
endmodule

// File: rtl/gpr_wb_merge.sv
module gpr_wb_merge
    import gpr_pkg::*;
#(
    parameter int NREGS       = 16,
    parameter int XLEN        = 64,
    parameter int LEGACY_REGS = 8,
    localparam int IW         = $clog2(NREGS),
    localparam int HALF       = XLEN / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_long,
    input  logic            wr_en,
    input  logic            wr_rex,
    input  logic [IW-1:0]   wr_idx,
    input  logic [1:0]      wr_width,
    input  logic [XLEN-1:0] wr_data,
    output logic            wr_err,
    input  logic [IW-1:0]   rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [IW-1:0]   rd_b_idx,
    output logic [XLEN-1:0] rd_b_data
);
    typedef struct packed {
        logic err;
    } st_t;

    st_t             st_d, st_q;
    wid_e            wid;
    logic            acc, rej;
    logic [XLEN-1:0] merged;
    logic [XLEN-1:0] regs [NREGS];

    assign wid = wid_e'(wr_width);

    gpr_access_check #(.NREGS(NREGS), .LEGACY_REGS(LEGACY_REGS)) u_chk (
        .req(wr_en), .long_mode(mode_long), .rex(wr_rex), .idx(wr_idx),
        .wid(wid), .accept(acc), .reject(rej)
    );

    gpr_merge #(.XLEN(XLEN)) u_mrg (
        .long_mode(mode_long), .wid(wid), .old_val(regs[wr_idx]),
        .new_val(wr_data), .merged(merged)
    );

    gpr_store #(.NREGS(NREGS), .XLEN(XLEN)) u_st (
        .clk(clk), .rst_n(rst_n), .we(acc), .widx(wr_idx),
        .wdata(merged), .regs_o(regs)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = rej;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_err = st_q.err;

    always_comb begin
        rd_a_data = regs[rd_a_idx];
        rd_b_data = regs[rd_b_idx];
        if (!mode_long) begin
            rd_a_data[XLEN-1:HALF] = '0;
            rd_b_data[XLEN-1:HALF] = '0;
        end
    end

    // R5: an unprefixed write to a high index in 64-bit mode raises the error next cycle
    assert_high_needs_rex_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_long && (int'(wr_idx) >= LEGACY_REGS) && !wr_rex) |=> wr_err);
    // R6: legacy mode never accepts a 64-bit write
    assert_legacy_no64_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_long && (wr_width == 2'd3)) |=> wr_err);
    // R9: no error follows an idle cycle
    assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_err);
    // R3: an accepted 32-bit write in 64-bit mode leaves the upper half cleared
    assert_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mode_long && (wr_width == 2'd2))
        |=> (regs[$past(wr_idx)][XLEN-1:HALF] == '0));
    // R4: an accepted 8-bit write keeps every bit above bit 7
    assert_keep_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (wr_width == 2'd0))
        |=> (regs[$past(wr_idx)][XLEN-1:8] == $past(regs[wr_idx][XLEN-1:8])));
    // R7: legacy reads never expose the upper half
    assert_legacy_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_long |-> (rd_a_data[XLEN-1:HALF] == '0 && rd_b_data[XLEN-1:HALF] == '0));
endmodule

// File: tb/sim_gpr_wb_merge.sv
`timescale 1ns/1ps
module sim_gpr_wb_merge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_long = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_rex = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [1:0]  wr_width = '0;
    logic [63:0] wr_data = '0;
    logic        wr_err;
    logic [3:0]  rd_a_idx = '0;
    logic [63:0] rd_a_data;
    logic [3:0]  rd_b_idx = '0;
    logic [63:0] rd_b_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [3:0]  idx;
        logic [63:0] exp;
        logic        err;
        string       tag;
    } item_t;

    item_t        sb[$];
    logic [63:0]  model [16];

    always #2 clk = ~clk;

    gpr_wb_merge u0 (
        .clk(clk), .rst_n(rst_n), .mode_long(mode_long), .wr_en(wr_en),
        .wr_rex(wr_rex), .wr_idx(wr_idx), .wr_width(wr_width), .wr_data(wr_data),
        .wr_err(wr_err), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] view(logic [63:0] v, logic lm);
        return lm ? v : {32'h0, v[31:0]};
    endfunction

    // driver: applies one cycle of stimulus on a falling edge and queues the expectation
    task automatic drive(logic lm, logic en, logic rex, logic [3:0] idx,
                         logic [1:0] w, logic [63:0] d, string tag);
        logic ok;
        logic [63:0] o, n;
        @(negedge clk);
        mode_long = lm; wr_en = en; wr_rex = rex; wr_idx = idx;
        wr_width = w; wr_data = d;
        o = model[idx];
        ok = en && (lm ? (idx < 8 || rex) : (idx < 8 && w != 2'd3));
        case (w)
            2'd0: n = {o[63:8], d[7:0]};
            2'd1: n = {o[63:16], d[15:0]};
            2'd2: n = lm ? {32'h0, d[31:0]} : {o[63:32], d[31:0]};
            default: n = d;
        endcase
        // R8: before the edge the port still shows the old contents
        rd_b_idx = idx;
        #0.5;
        check({"R8 pre-edge ", tag}, rd_b_data, view(o, lm));
        if (ok) model[idx] = n;
        sb.push_back('{idx, view(model[idx], lm), !ok && en, tag});
    endtask

    // monitor: pops one expectation after each edge and compares
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                rd_a_idx = it.idx;
                #0.5;
                check(it.tag, rd_a_data, it.exp);
                check({it.tag, " err"}, {63'h0, wr_err}, {63'h0, it.err});
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < 16; i++) begin
            rd_b_idx = 4'(i);
            #0.1;
            check("R1 reset reg", rd_b_data, 64'h0);
        end
        check("R1 reset err", {63'h0, wr_err}, 64'h0);

        drive(1, 1, 0, 4'd3, 2'd3, 64'hA5A5_A5A5_A5A5_A5A5, "R2 full write");
        drive(1, 1, 0, 4'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FF3C, "R4 byte merge");
        drive(1, 1, 0, 4'd3, 2'd1, 64'h1111_2222_3333_BEEF, "R4 half merge");
        drive(1, 1, 0, 4'd3, 2'd2, 64'hDEAD_DEAD_CAFE_F00D, "R3 zero extend");
        drive(1, 1, 1, 4'd9, 2'd3, 64'h0123_4567_89AB_CDEF, "R5 rex high write");
        drive(1, 1, 0, 4'd9, 2'd3, 64'hFFFF_0000_FFFF_0000, "R5 no rex dropped");
        drive(1, 0, 0, 4'd9, 2'd3, 64'h0, "R9 idle no err");
        drive(1, 1, 1, 4'd12, 2'd3, 64'h7777_7777_7777_7777, "R2 high full");
        drive(1, 1, 1, 4'd12, 2'd2, 64'h8888_8888_1234_0000, "R3 high zero extend");
        drive(1, 1, 0, 4'd2, 2'd3, 64'hFFFF_FFFF_0000_0000, "R2 setup");
        drive(0, 1, 0, 4'd2, 2'd2, 64'h9999_9999_1234_5678, "R7 legacy 32 write");
        drive(1, 0, 0, 4'd2, 2'd0, 64'h0, "R7 upper kept");
        drive(0, 1, 0, 4'd1, 2'd3, 64'h5555_5555_5555_5555, "R6 legacy 64 dropped");
        drive(0, 1, 1, 4'd10, 2'd0, 64'h42, "R6 legacy high dropped");
        drive(0, 1, 1, 4'd4, 2'd1, 64'hABCD, "R6 legacy 16 accepted");
        drive(0, 1, 0, 4'd3, 2'd0, 64'h5A, "R4 legacy byte");
        drive(1, 0, 0, 4'd3, 2'd0, 64'h0, "R4 byte keeps upper");
        drive(1, 0, 0, 4'd9, 2'd0, 64'h0, "R9 idle after ok");
        repeat (3) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule